// File: doc/BRIEF.md
# Clear-on-read error counter bank

This block keeps the error tallies of a DS3/E3-style line receiver. Upstream detectors give it one-cycle strobes for parity errors, the two halves of a path disagreement check, frame alignment errors, far-end block errors and line-code violations. A processor reads the tallies through a read strobe and a small address. Every read returns the value one cycle later and clears the counter it touched. A strobe that arrives in the same cycle as the read is counted into the fresh count, so no event is lost and none is counted twice.

Each counter has an interrupt enable. When the enable is clear, the counter stops at its maximum and raises its flag in a shared status word. When the enable is set, the counter wraps to zero, raises its flag and drives the interrupt output. A separate control makes the frame and line-code counters wrap silently. Each of these two counters drives a carry pulse, so external logic can widen it without help from the processor. During out-of-frame, and in E3 mode, only the frame and line-code counters keep counting.

Top module: `ecb_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter, every status flag, `rd_data`, `cnt_irq`, `lcv_carry` and `frame_carry` are zero.
- R2: Each strobe adds one to its counter. When `rd_en` is high in a cycle, `rd_data` shows the addressed value from the next cycle on. Addresses: 0 parity, 1 disagreement, 2 frame, 3 far-end, 4 line-code low byte, 5 line-code high byte, 6 status, 7 reads zero.
- R3: If a counter's interrupt enable is 0, it holds at its maximum (255 for 8-bit counters) when another strobe arrives. The same strobe sets its status flag. `cnt_irq` stays low.
- R4: If a counter's interrupt enable is 1, a strobe at the maximum wraps it to 0 and sets its flag. `cnt_irq` goes high and stays high until the flag is cleared.
- R5: Reading a counter clears it and its status flag. A strobe in the read cycle leaves that counter at 1.
- R6: A read of address 6 returns the flags (bit0 parity, bit1 disagreement, bit2 frame, bit3 far-end, bit4 line-code) and clears them. A flag event in that same cycle stays pending.
- R7: The line-code counter is 16 bits wide. Address 4 returns and clears only the low byte, and address 5 only the high byte. A carry out of the low byte in the cycle that the high byte is read leaves the high byte at 1. Reading the high byte clears the line-code flag.
- R8: Address 1 holds two 4-bit counts: bits 3:0 count `err_disag[0]` and bits 7:4 count `err_disag[1]`. Each saturates at 15 or wraps, like the other counters. Both clear on a read of address 1.
- R9: While `oof` is high, strobes to the parity, disagreement and far-end counters are ignored. The frame and line-code counters keep counting.
- R10: While `e3_mode` is high, only the frame and line-code counters count.
- R11: With `sat_dis` high, the frame and line-code counters wrap at their maximum without setting a flag. `frame_carry` or `lcv_carry` pulses high for one cycle, in the cycle after the wrapping strobe.
- R12: `cnt_irq` is the OR of those flags whose interrupt enable is currently set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e3_mode | input | 1 | E3 operation: only frame and line-code counters active |
| oof | input | 1 | Out-of-frame: freezes parity, disagreement and far-end counters |
| sat_dis | input | 1 | Silent wrap for frame and line-code counters |
| int_en | input | 5 | Per-counter interrupt enable, same bit order as the status word |
| err_par | input | 1 | Parity error strobe |
| err_disag | input | 2 | Disagreement strobes for the two nibble counts |
| err_frame | input | 1 | Frame alignment word error strobe |
| err_feb | input | 1 | Far-end block error strobe |
| err_lcv | input | 1 | Line-code violation strobe |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| cnt_irq | output | 1 | Counter interrupt |
| lcv_carry | output | 1 | Line-code counter wrap pulse |
| frame_carry | output | 1 | Frame counter wrap pulse |

## Verification
The hardest cases to reach are events that land in the same cycle as a clear: a strobe into a counter being read, a low-byte carry while the high byte is read, and a wrap while the status word is read. From the ports, this needs the counter to be brought to exactly its maximum first. Directed sequences pulse a strobe a precise number of times and then issue the read in the same cycle as the final strobe. The 16-bit line-code counter is driven through all 65536 values to reach its silent wrap. A long random phase then mixes strobes, reads and mode changes against a behavioural model that is compared every cycle.

// File: rtl/ecb_pkg.sv
`timescale 1ns/1ps
// Shared constants of the error counter bank: read address map and the
// bit position of each counter's flag in the status word.
package ecb_pkg;
    localparam int ADDR_W    = 3;
    localparam int NUM_FLAGS = 5;
    localparam int NUM_NIB   = 2;

    localparam int FLG_PAR = 0;
    localparam int FLG_DIS = 1;
    localparam int FLG_FRM = 2;
    localparam int FLG_FEB = 3;
    localparam int FLG_LCV = 4;

    localparam logic [ADDR_W-1:0] A_PAR    = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIS    = 3'd1;
    localparam logic [ADDR_W-1:0] A_FRM    = 3'd2;
    localparam logic [ADDR_W-1:0] A_FEB    = 3'd3;
    localparam logic [ADDR_W-1:0] A_LCV_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_LCV_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd6;
endpackage

// File: rtl/ecb_sat_ctr.sv
`timescale 1ns/1ps
// Single error counter of parameter width.
// What it does: counts one per inc pulse. It either holds at its maximum
// (sat_evt) or wraps to zero (wrap_evt), as wrap_mode selects. clr empties
// the counter before the increment is applied, so an inc in the clearing
// cycle leaves the count at 1.
// Assumes: the caller gates inc for freeze and mode conditions.
module ecb_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    input  logic         wrap_mode,
    output logic [W-1:0] count,
    output logic         sat_evt,
    output logic         wrap_evt
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] count_q;
    logic [W-1:0] base;
    logic [W-1:0] next;
    logic         full;

    // Next-count arithmetic: clear first, then add the strobe.
    always_comb begin
        base     = clr ? '0 : count_q;
        full     = (base == MAXV);
        sat_evt  = inc & full & ~wrap_mode;
        wrap_evt = inc & full & wrap_mode;
        next     = sat_evt ? base : base + W'(inc);
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= next;
    end

    assign count = count_q;

    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !wrap_mode && count_q == MAXV) |=> (count_q == MAXV));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && wrap_mode && count_q == MAXV) |=> (count_q == '0));

    p_clear_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == W'($past(inc))));
endmodule

// File: rtl/ecb_split_ctr.sv
`timescale 1ns/1ps
// Two-byte error counter whose bytes are cleared separately.
// What it does: keeps one 2*BYTE_W count. A read of either byte zeroes that
// byte before the increment is added, so a carry out of the low byte in the
// cycle that the high byte is read lands in the fresh high byte. It
// saturates at all ones or wraps, and registers a one-cycle carry pulse on
// each wrap.
// Assumes: software reads the low byte before the high byte.
module ecb_split_ctr #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              clr_lo,
    input  logic              clr_hi,
    input  logic              wrap_mode,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              sat_evt,
    output logic              wrap_evt,
    output logic              carry
);
    localparam int TW = 2 * BYTE_W;

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] base;
    logic [TW-1:0] next;
    logic          full;
    logic          carry_q;

    // Merge the per-byte clears, then apply the strobe to the whole count.
    always_comb begin
        base[BYTE_W-1:0]  = clr_lo ? '0 : cnt_q[BYTE_W-1:0];
        base[TW-1:BYTE_W] = clr_hi ? '0 : cnt_q[TW-1:BYTE_W];
        full     = &base;
        sat_evt  = inc & full & ~wrap_mode;
        wrap_evt = inc & full & wrap_mode;
        next     = sat_evt ? base : base + TW'(inc);
    end

    // Count and carry-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            cnt_q   <= next;
            carry_q <= wrap_evt;
        end
    end

    assign lo    = cnt_q[BYTE_W-1:0];
    assign hi    = cnt_q[TW-1:BYTE_W];
    assign carry = carry_q;

    p_lo_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lo && !inc) |=> (lo == '0));

    p_hi_keeps_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hi && !clr_lo && inc && (&lo)) |=> (hi == BYTE_W'(1)));

    p_carry_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (cnt_q == '0));
endmodule

// File: rtl/ecb_status.sv
`timescale 1ns/1ps
// Counter status word and interrupt.
// What it does: each flag is set by its counter's event and cleared by its
// clear request. A set in the same cycle as a clear wins and stays pending.
// The interrupt is the OR of the flags whose enable is set.
// Assumes: set and clr are single-cycle requests from the same clock domain.
module ecb_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] int_en,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] flags_q;

    // Flag register: clear, then set on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr) | set;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & int_en);

    p_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flags_q & $past(set)) == $past(set)));

    p_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((flags_q & $past(clr & ~set)) == '0));
endmodule

// File: rtl/ecb_counter_bank.sv
`timescale 1ns/1ps
// Error counter bank with clear-on-read access.
// What it does: five error tallies (parity, two-nibble disagreement, frame,
// far-end and a 16-bit line-code count) behind a registered read port. Reads
// clear the addressed counter and its flag. Counters saturate or wrap as
// their interrupt enable selects, and the frame and line-code counters can
// be told to wrap silently for external widening through their carry pulses.
// Assumes: strobes are one cycle long and synchronous to clk. The read
// address is decoded only while rd_en is high.
module ecb_counter_bank
    import ecb_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int NIB_W      = 4,
    parameter int LCV_BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 e3_mode,
    input  logic                 oof,
    input  logic                 sat_dis,
    input  logic [NUM_FLAGS-1:0] int_en,
    input  logic                 err_par,
    input  logic [NUM_NIB-1:0]   err_disag,
    input  logic                 err_frame,
    input  logic                 err_feb,
    input  logic                 err_lcv,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [CNT_W-1:0]     rd_data,
    output logic                 cnt_irq,
    output logic                 lcv_carry,
    output logic                 frame_carry
);
    localparam int DATA_W = CNT_W;

    logic                 legacy_live;
    logic                 rd_par, rd_dis, rd_frm, rd_feb, rd_lo, rd_hi, rd_stat;
    logic [CNT_W-1:0]     par_cnt, frm_cnt, feb_cnt;
    logic [NIB_W-1:0]     nib_cnt [NUM_NIB];
    logic [NUM_NIB-1:0]   nib_sat, nib_wrap;
    logic [LCV_BYTE_W-1:0] lcv_lo, lcv_hi;
    logic                 par_sat, par_wrap, frm_sat, frm_wrap, feb_sat, feb_wrap;
    logic                 lcv_sat, lcv_wrap, lcv_cy;
    logic [NUM_FLAGS-1:0] flg_set, flg_clr, flags;
    logic                 irq;
    logic                 frame_carry_q;
    logic [DATA_W-1:0]    rd_mux, rd_q;

    // Read decode and the condition under which frozen counters may count.
    always_comb begin
        legacy_live = ~oof & ~e3_mode;
        rd_par  = rd_en && (rd_addr == A_PAR);
        rd_dis  = rd_en && (rd_addr == A_DIS);
        rd_frm  = rd_en && (rd_addr == A_FRM);
        rd_feb  = rd_en && (rd_addr == A_FEB);
        rd_lo   = rd_en && (rd_addr == A_LCV_LO);
        rd_hi   = rd_en && (rd_addr == A_LCV_HI);
        rd_stat = rd_en && (rd_addr == A_STAT);
    end

    ecb_sat_ctr #(.W(CNT_W)) u_par (
        .clk(clk), .rst_n(rst_n), .inc(err_par & legacy_live), .clr(rd_par),
        .wrap_mode(int_en[FLG_PAR]), .count(par_cnt),
        .sat_evt(par_sat), .wrap_evt(par_wrap));

    for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
        ecb_sat_ctr #(.W(NIB_W)) u_nib (
            .clk(clk), .rst_n(rst_n), .inc(err_disag[g] & legacy_live),
            .clr(rd_dis), .wrap_mode(int_en[FLG_DIS]), .count(nib_cnt[g]),
            .sat_evt(nib_sat[g]), .wrap_evt(nib_wrap[g]));
    end

    ecb_sat_ctr #(.W(CNT_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .inc(err_frame), .clr(rd_frm),
        .wrap_mode(int_en[FLG_FRM] | sat_dis), .count(frm_cnt),
        .sat_evt(frm_sat), .wrap_evt(frm_wrap));

    ecb_sat_ctr #(.W(CNT_W)) u_feb (
        .clk(clk), .rst_n(rst_n), .inc(err_feb & legacy_live), .clr(rd_feb),
        .wrap_mode(int_en[FLG_FEB]), .count(feb_cnt),
        .sat_evt(feb_sat), .wrap_evt(feb_wrap));

    ecb_split_ctr #(.BYTE_W(LCV_BYTE_W)) u_lcv (
        .clk(clk), .rst_n(rst_n), .inc(err_lcv), .clr_lo(rd_lo), .clr_hi(rd_hi),
        .wrap_mode(int_en[FLG_LCV] | sat_dis), .lo(lcv_lo), .hi(lcv_hi),
        .sat_evt(lcv_sat), .wrap_evt(lcv_wrap), .carry(lcv_cy));

    // Flag events: saturation always, wrap only when the interrupt is enabled.
    always_comb begin
        flg_set[FLG_PAR] = par_sat | (par_wrap & int_en[FLG_PAR]);
        flg_set[FLG_DIS] = (|nib_sat) | ((|nib_wrap) & int_en[FLG_DIS]);
        flg_set[FLG_FRM] = frm_sat | (frm_wrap & int_en[FLG_FRM]);
        flg_set[FLG_FEB] = feb_sat | (feb_wrap & int_en[FLG_FEB]);
        flg_set[FLG_LCV] = lcv_sat | (lcv_wrap & int_en[FLG_LCV]);
        flg_clr[FLG_PAR] = rd_stat | rd_par;
        flg_clr[FLG_DIS] = rd_stat | rd_dis;
        flg_clr[FLG_FRM] = rd_stat | rd_frm;
        flg_clr[FLG_FEB] = rd_stat | rd_feb;
        flg_clr[FLG_LCV] = rd_stat | rd_hi;
    end

    ecb_status #(.N(NUM_FLAGS)) u_stat (
        .clk(clk), .rst_n(rst_n), .set(flg_set), .clr(flg_clr),
        .int_en(int_en), .flags(flags), .irq(irq));

    // Read multiplexer over the pre-clear values.
    always_comb begin
        case (rd_addr)
            A_PAR:    rd_mux = par_cnt;
            A_DIS:    rd_mux = DATA_W'({nib_cnt[1], nib_cnt[0]});
            A_FRM:    rd_mux = frm_cnt;
            A_FEB:    rd_mux = feb_cnt;
            A_LCV_LO: rd_mux = DATA_W'(lcv_lo);
            A_LCV_HI: rd_mux = DATA_W'(lcv_hi);
            A_STAT:   rd_mux = DATA_W'(flags);
            default:  rd_mux = '0;
        endcase
    end

    // Read data and frame carry registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q          <= '0;
            frame_carry_q <= 1'b0;
        end else begin
            if (rd_en) rd_q <= rd_mux;
            frame_carry_q <= frm_wrap;
        end
    end

    assign rd_data     = rd_q;
    assign cnt_irq     = irq;
    assign lcv_carry   = lcv_cy;
    assign frame_carry = frame_carry_q;

    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (oof && !rd_par) |=> $stable(par_cnt));

    p_e3_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (e3_mode && !rd_feb) |=> $stable(feb_cnt));

    p_frame_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_carry |-> (frm_cnt == '0));
endmodule

// File: tb/ecb_counter_bank_tb_top.sv
`timescale 1ns/1ps
module ecb_counter_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e3_mode = 0, oof = 0, sat_dis = 0;
    logic [4:0] int_en = '0;
    logic       err_par = 0, err_frame = 0, err_feb = 0, err_lcv = 0;
    logic [1:0] err_disag = '0;
    logic       rd_en = 0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cnt_irq, lcv_carry, frame_carry;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural model state
    int       m_par, m_na, m_nb, m_frm, m_feb, m_lo, m_hi, m_rd;
    bit [4:0] m_flags;
    bit       m_lc, m_fc;

    always #2.5 clk = ~clk;

    ecb_counter_bank dut_i (
        .clk(clk), .rst_n(rst_n), .e3_mode(e3_mode), .oof(oof), .sat_dis(sat_dis),
        .int_en(int_en), .err_par(err_par), .err_disag(err_disag),
        .err_frame(err_frame), .err_feb(err_feb), .err_lcv(err_lcv),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_irq(cnt_irq),
        .lcv_carry(lcv_carry), .frame_carry(frame_carry));

    task automatic model_reset();
        m_par = 0; m_na = 0; m_nb = 0; m_frm = 0; m_feb = 0;
        m_lo = 0; m_hi = 0; m_rd = 0; m_flags = '0; m_lc = 0; m_fc = 0;
    endtask

    task automatic bump(inout int c, input bit inc, input bit clr, input bit wrapm,
                        input int maxv, output bit sat, output bit wr);
        int b;
        b = clr ? 0 : c;
        sat = 0; wr = 0;
        if (inc) begin
            if (b == maxv) begin
                if (wrapm) begin b = 0; wr = 1; end
                else sat = 1;
            end else b = b + 1;
        end
        c = b;
    endtask

    function automatic int peek(input logic [2:0] a);
        case (a)
            3'd0: return m_par;
            3'd1: return m_nb * 16 + m_na;
            3'd2: return m_frm;
            3'd3: return m_feb;
            3'd4: return m_lo;
            3'd5: return m_hi;
            3'd6: return int'(m_flags);
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        bit live, rp, rdi, rf, rfe, rl, rh, rs;
        bit s0, w0, sa, wa, sb, wb, s2, w2, s3, w3, s4, w4;
        bit [4:0] st, cl;
        int v;
        live = !oof && !e3_mode;
        rp  = rd_en && rd_addr == 3'd0; rdi = rd_en && rd_addr == 3'd1;
        rf  = rd_en && rd_addr == 3'd2; rfe = rd_en && rd_addr == 3'd3;
        rl  = rd_en && rd_addr == 3'd4; rh  = rd_en && rd_addr == 3'd5;
        rs  = rd_en && rd_addr == 3'd6;
        if (rd_en) m_rd = peek(rd_addr);
        bump(m_par, err_par && live, rp, int_en[0], 255, s0, w0);
        bump(m_na, err_disag[0] && live, rdi, int_en[1], 15, sa, wa);
        bump(m_nb, err_disag[1] && live, rdi, int_en[1], 15, sb, wb);
        bump(m_frm, err_frame, rf, int_en[2] || sat_dis, 255, s2, w2);
        bump(m_feb, err_feb && live, rfe, int_en[3], 255, s3, w3);
        v = (rh ? 0 : m_hi) * 256 + (rl ? 0 : m_lo);
        bump(v, err_lcv, 1'b0, int_en[4] || sat_dis, 65535, s4, w4);
        m_lo = v % 256; m_hi = v / 256;
        st[0] = s0 | (w0 & int_en[0]);
        st[1] = (sa | sb) | ((wa | wb) & int_en[1]);
        st[2] = s2 | (w2 & int_en[2]);
        st[3] = s3 | (w3 & int_en[3]);
        st[4] = s4 | (w4 & int_en[4]);
        cl = {rs | rh, rs | rfe, rs | rf, rs | rdi, rs | rp};
        m_flags = (m_flags & ~cl) | st;
        m_lc = w4; m_fc = w2;
    endtask

    task automatic compare();
        bit bad;
        bad = 0;
        vectors++;
        if (rd_data !== 8'(m_rd)) begin
            $display("FAIL %s rd_data actual %0d expected %0d", cur_req, rd_data, m_rd); bad = 1;
        end
        if (cnt_irq !== |(m_flags & int_en)) begin
            $display("FAIL %s cnt_irq actual %0b expected %0b", cur_req, cnt_irq, |(m_flags & int_en)); bad = 1;
        end
        if (lcv_carry !== m_lc) begin
            $display("FAIL %s lcv_carry actual %0b expected %0b", cur_req, lcv_carry, m_lc); bad = 1;
        end
        if (frame_carry !== m_fc) begin
            $display("FAIL %s frame_carry actual %0b expected %0b", cur_req, frame_carry, m_fc); bad = 1;
        end
        if (bad) fails++;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        err_par = 0; err_disag = '0; err_frame = 0; err_feb = 0; err_lcv = 0; rd_en = 0;
    endtask

    task automatic rd(input logic [2:0] a);
        rd_en = 1; rd_addr = a; tick();
    endtask

    // explicit check against a value taken from the requirement text
    task automatic want(input int act, input int exp, input string req);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        compare();
        want(int'(rd_data), 0, "R1");
        want(int'(cnt_irq), 0, "R1");

        // R2: plain counting and read-back
        cur_req = "R2";
        repeat (10) begin err_par = 1; tick(); end
        rd(3'd0); want(int'(rd_data), 10, "R2");
        rd(3'd7); want(int'(rd_data), 0, "R2");
        cur_req = "R5";
        rd(3'd0); want(int'(rd_data), 0, "R5");

        // R3: saturation with interrupt disabled
        cur_req = "R3";
        repeat (260) begin err_frame = 1; tick(); end
        want(int'(cnt_irq), 0, "R3");
        rd(3'd6); want(int'(rd_data), 4, "R3");
        rd(3'd2); want(int'(rd_data), 255, "R3");
        rd(3'd6); want(int'(rd_data), 0, "R3");

        // R4: wrap with interrupt enabled
        cur_req = "R4";
        int_en = 5'b00001;
        repeat (256) begin err_par = 1; tick(); end
        want(int'(cnt_irq), 1, "R4");
        repeat (3) begin err_par = 1; tick(); end
        want(int'(cnt_irq), 1, "R4");
        rd(3'd6); want(int'(rd_data), 1, "R4");
        want(int'(cnt_irq), 0, "R4");
        rd(3'd0); want(int'(rd_data), 3, "R4");

        // R5: strobe coinciding with the clearing read
        cur_req = "R5";
        repeat (5) begin err_par = 1; tick(); end
        err_par = 1; rd(3'd0); want(int'(rd_data), 5, "R5");
        rd(3'd0); want(int'(rd_data), 1, "R5");

        // R6: wrap in the cycle of the status read stays pending
        cur_req = "R6";
        repeat (255) begin err_par = 1; tick(); end
        err_par = 1; rd(3'd6); want(int'(rd_data), 0, "R6");
        want(int'(cnt_irq), 1, "R6");
        rd(3'd6); want(int'(rd_data), 1, "R6");
        int_en = '0;

        // R7: split line-code counter
        cur_req = "R7";
        repeat (300) begin err_lcv = 1; tick(); end
        rd(3'd4); want(int'(rd_data), 44, "R7");
        rd(3'd5); want(int'(rd_data), 1, "R7");
        rd(3'd4); want(int'(rd_data), 0, "R7");
        repeat (255) begin err_lcv = 1; tick(); end
        err_lcv = 1; rd(3'd5); want(int'(rd_data), 0, "R7");
        rd(3'd4); want(int'(rd_data), 0, "R7");
        rd(3'd5); want(int'(rd_data), 1, "R7");

        // R8: nibble pair
        cur_req = "R8";
        repeat (5)  begin err_disag = 2'b01; tick(); end
        repeat (20) begin err_disag = 2'b10; tick(); end
        rd(3'd6); want(int'(rd_data), 2, "R8");
        rd(3'd1); want(int'(rd_data), 8'hF5, "R8");
        rd(3'd1); want(int'(rd_data), 0, "R8");

        // R9: out-of-frame freeze
        cur_req = "R9";
        oof = 1;
        repeat (3) begin
            err_par = 1; err_disag = 2'b11; err_feb = 1; err_frame = 1; err_lcv = 1; tick();
        end
        oof = 0;
        rd(3'd0); want(int'(rd_data), 0, "R9");
        rd(3'd1); want(int'(rd_data), 0, "R9");
        rd(3'd3); want(int'(rd_data), 0, "R9");
        rd(3'd2); want(int'(rd_data), 3, "R9");
        rd(3'd4); want(int'(rd_data), 3, "R9");

        // R10: E3 mode
        cur_req = "R10";
        e3_mode = 1;
        repeat (4) begin
            err_par = 1; err_disag = 2'b11; err_feb = 1; err_frame = 1; err_lcv = 1; tick();
        end
        rd(3'd3); want(int'(rd_data), 0, "R10");
        rd(3'd0); want(int'(rd_data), 0, "R10");
        rd(3'd1); want(int'(rd_data), 0, "R10");
        rd(3'd2); want(int'(rd_data), 4, "R10");
        rd(3'd4); want(int'(rd_data), 4, "R10");
        e3_mode = 0;

        // R11: silent wrap and carry pulses
        cur_req = "R11";
        sat_dis = 1;
        repeat (256) begin err_frame = 1; tick(); end
        want(int'(frame_carry), 1, "R11");
        tick(); want(int'(frame_carry), 0, "R11");
        rd(3'd4); rd(3'd5);
        repeat (65536) begin err_lcv = 1; tick(); end
        want(int'(lcv_carry), 1, "R11");
        rd(3'd6); want(int'(rd_data), 0, "R11");
        want(int'(lcv_carry), 0, "R11");
        sat_dis = 0;

        // R12: interrupt follows live enables
        cur_req = "R12";
        int_en = 5'b01000;
        repeat (256) begin err_feb = 1; tick(); end
        want(int'(cnt_irq), 1, "R12");
        int_en = '0; #1; want(int'(cnt_irq), 0, "R12");
        int_en = 5'b01000; #1; want(int'(cnt_irq), 1, "R12");
        rd(3'd6); want(int'(rd_data), 8, "R12");

        // mixed random traffic checked against the model every cycle
        cur_req = "R2 R5 R6 mixed";
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) begin
                int_en = 5'($urandom); sat_dis = 1'($urandom);
                oof = ($urandom % 4) == 0; e3_mode = ($urandom % 5) == 0;
            end
            err_par = ($urandom % 3) != 0; err_disag = 2'($urandom);
            err_frame = ($urandom % 2) != 0; err_feb = ($urandom % 3) != 0;
            err_lcv = ($urandom % 2) != 0;
            rd_en = ($urandom % 40) == 0; rd_addr = 3'($urandom);
            tick();
        end
        finish_run();
    end
endmodule